// File: doc/BRIEF.md
# Packed Saturating Subword Adder

This block performs one SIMD add-class operation per clock on a 64-bit word that is cut into equal lanes. The lane width is chosen at run time: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Carries and borrows never cross a lane boundary. The operation is also chosen at run time. The choices are modular add or subtract, unsigned clamping add or subtract, signed clamping add or subtract, and an unsigned rounded mean of the two operands.

For each lane, the unit reports whether that lane's result was clamped. It is meant for a media datapath that feeds it two packed operands and a pair of control codes each cycle. The result and flags appear on registered outputs one clock later, so each operation completes in a single stage.

Top module: `packed_lane_alu`

## Requirements
- R1: The lane-size code `lane_sel_i` selects 8-bit lanes for 2'b00, 16-bit lanes for 2'b01 and 32-bit lanes for 2'b10. Lane k occupies bits [k*W+W-1 : k*W]. Code 2'b11 is reserved and produces an all-zero result and all-zero flags.
- R2: Op code 3'd0 (modular add) and op code 3'd1 (modular subtract) give each lane the low W bits of its sum or difference. No carry or borrow passes into the neighbouring lane.
- R3: Op code 3'd2 (unsigned clamping add) returns all ones for any lane whose unsigned sum exceeds 2^W-1.
- R4: Op code 3'd3 (unsigned clamping subtract) returns zero for any lane where b is greater than a.
- R5: Op codes 3'd4 (signed clamping add) and 3'd5 (signed clamping subtract) treat lanes as two's complement. A lane whose result overflows is clamped to the most positive value or the most negative value, according to the direction of the overflow.
- R6: Op code 3'd6 gives each lane the unsigned value (a+b+1)>>1. The sum is formed with enough bits that the full-scale inputs FF+FF give FF in 8-bit lanes.
- R7: Flag bit k of `sat_o` is 1 exactly when lane k was clamped. Flags stay 0 for the modular and mean ops. Flag bits at or above the current lane count are 0.
- R8: Op code 3'd7 is reserved and produces an all-zero result and all-zero flags.
- R9: The result and flags are registered with one cycle of latency. A synchronous active-low reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_i | input | 64 | First packed operand (a) |
| opb_i | input | 64 | Second packed operand (b) |
| lane_sel_i | input | 2 | Lane-size code |
| op_i | input | 3 | Operation code |
| res_o | output | 64 | Registered packed result |
| sat_o | output | 8 | Registered per-lane clamp flags |

## Verification
The bench builds the block with its default parameters: a 64-bit word and an 8-bit minimum lane. These defaults produce all three lane widths, so the eight-flag, four-flag and two-flag cases can all be reached. With them, the vectors can place a lane boundary next to a carry at each width. They can also reach the full-scale extremes for the clamp and mean paths, and both reserved codes.

// File: rtl/pla_pkg.sv
// Package: shared operation codes for the packed lane ALU.
// Assumes a 3-bit operation field; code 7 is reserved.
package pla_pkg;

    typedef enum logic [2:0] {
        OP_ADD_MOD  = 3'd0,
        OP_SUB_MOD  = 3'd1,
        OP_ADD_USAT = 3'd2,
        OP_SUB_USAT = 3'd3,
        OP_ADD_SSAT = 3'd4,
        OP_SUB_SSAT = 3'd5,
        OP_AVG_U    = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/pla_lane.sv
// Module: pla_lane
// One lane of width W. Computes the selected add-class op for a single
// lane and reports whether the result was clamped.
// Assumes the op code is valid; reserved codes yield zero and no flag.
module pla_lane
    import pla_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  op_e          op_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] S_MAX    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN    = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic [W:0] rnd_x;
    logic       sadd_ovf;
    logic       ssub_ovf;

    // Extended sum, difference and rounded sum for this lane.
    always_comb begin
        sum_x = {1'b0, a_i} + {1'b0, b_i};
        dif_x = {1'b0, a_i} - {1'b0, b_i};
        rnd_x = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, 1'b1};
    end

    // Signed overflow detection from operand and result sign bits.
    always_comb begin
        sadd_ovf = (a_i[W-1] == b_i[W-1]) && (sum_x[W-1] != a_i[W-1]);
        ssub_ovf = (a_i[W-1] != b_i[W-1]) && (dif_x[W-1] != a_i[W-1]);
    end

    // Result and clamp selection per operation.
    always_comb begin
        res_o = '0;
        sat_o = 1'b0;
        unique case (op_i)
            OP_ADD_MOD:  res_o = sum_x[W-1:0];
            OP_SUB_MOD:  res_o = dif_x[W-1:0];
            OP_ADD_USAT: begin
                sat_o = sum_x[W];
                res_o = sum_x[W] ? ALL_ONES : sum_x[W-1:0];
            end
            OP_SUB_USAT: begin
                sat_o = dif_x[W];
                res_o = dif_x[W] ? '0 : dif_x[W-1:0];
            end
            OP_ADD_SSAT: begin
                sat_o = sadd_ovf;
                res_o = sadd_ovf ? (a_i[W-1] ? S_MIN : S_MAX) : sum_x[W-1:0];
            end
            OP_SUB_SSAT: begin
                sat_o = ssub_ovf;
                res_o = ssub_ovf ? (a_i[W-1] ? S_MIN : S_MAX) : dif_x[W-1:0];
            end
            OP_AVG_U:    res_o = rnd_x[W:1];
            default: begin
                res_o = '0;
                sat_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pla_bank.sv
// Module: pla_bank
// A full word of lanes at one fixed lane width. Flags are packed from
// bit 0; flag positions beyond the lane count are tied to zero.
// Assumes DATA_W is a multiple of LANE_W and FLAG_W >= DATA_W/LANE_W.
module pla_bank
    import pla_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int FLAG_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  op_e               op_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flag_o
);

    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        pla_lane #(.W(LANE_W)) u_lane (
            .a_i   (a_i[k*LANE_W +: LANE_W]),
            .b_i   (b_i[k*LANE_W +: LANE_W]),
            .op_i  (op_i),
            .res_o (res_o[k*LANE_W +: LANE_W]),
            .sat_o (flag_o[k])
        );
    end

    if (N_LANES < FLAG_W) begin : g_pad
        assign flag_o[FLAG_W-1:N_LANES] = '0;
    end

endmodule

// File: rtl/packed_lane_alu.sv
// Module: packed_lane_alu (top)
// Packed add/subtract/clamp/mean unit. Builds one lane bank per lane
// width, selects the bank named by the lane-size code, and registers the
// result and flags. Assumes DATA_W is a multiple of MIN_LANE_W << 2.
module packed_lane_alu
    import pla_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MIN_LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           opa_i,
    input  logic [DATA_W-1:0]           opb_i,
    input  logic [1:0]                  lane_sel_i,
    input  logic [2:0]                  op_i,
    output logic [DATA_W-1:0]           res_o,
    output logic [DATA_W/MIN_LANE_W-1:0] sat_o
);

    localparam int FLAG_W = DATA_W / MIN_LANE_W;

    op_e              op_c;
    logic [DATA_W-1:0] bank_res  [NUM_SIZES];
    logic [FLAG_W-1:0] bank_flag [NUM_SIZES];
    logic [DATA_W-1:0] res_d;
    logic [FLAG_W-1:0] sat_d;

    assign op_c = op_e'(op_i);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        pla_bank #(
            .DATA_W (DATA_W),
            .LANE_W (MIN_LANE_W << s),
            .FLAG_W (FLAG_W)
        ) u_bank (
            .a_i    (opa_i),
            .b_i    (opb_i),
            .op_i   (op_c),
            .res_o  (bank_res[s]),
            .flag_o (bank_flag[s])
        );
    end

    // Pick the bank for the requested lane width; reserved code gives zero.
    always_comb begin
        res_d = '0;
        sat_d = '0;
        if (lane_sel_i < 2'(NUM_SIZES)) begin
            res_d = bank_res[lane_sel_i];
            sat_d = bank_flag[lane_sel_i];
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
            sat_o <= '0;
        end else begin
            res_o <= res_d;
            sat_o <= sat_d;
        end
    end

    AST_RSVD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lane_sel_i) == 2'b11) |-> (res_o == '0 && sat_o == '0)); // R1
    AST_RSVD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 3'd7) |-> (res_o == '0 && sat_o == '0)); // R8
    AST_NOCLAMP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) <= 3'd1 || $past(op_i) == 3'd6)) |-> (sat_o == '0)); // R7
    AST_WIDE_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lane_sel_i) == 2'b10) |-> ($countones(sat_o) <= 2 && sat_o[FLAG_W-1:2] == '0)); // R7
    AST_USAT_ADD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 3'd2 && $past(lane_sel_i) == 2'b00 && sat_o[0])
        |-> (res_o[MIN_LANE_W-1:0] == {MIN_LANE_W{1'b1}})); // R3
    AST_USAT_SUB_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 3'd3 && $past(lane_sel_i) == 2'b00 && sat_o[0])
        |-> (res_o[MIN_LANE_W-1:0] == '0)); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        (!$past(rst_n) && $past(rst_n, 2) == 1'b0) |-> (res_o == '0 && sat_o == '0)); // R9

endmodule

// File: tb/packed_lane_alu_bench.sv
module packed_lane_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [1:0]  lsel = '0;
    logic [2:0]  op = '0;
    logic [63:0] res;
    logic [7:0]  sat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    packed_lane_alu u_packed_lane_alu (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb),
        .lane_sel_i(lsel), .op_i(op), .res_o(res), .sat_o(sat)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic [2:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] er;
        logic [7:0]  ef;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R2: 8-bit modular add, carry cut at lane 0/1 boundary
        '{2'b00, 3'd0, 64'h00000000_000000FF, 64'h00000000_00000001, 64'h0, 8'h00},
        // R3: 8-bit unsigned clamp add, one lane
        '{2'b00, 3'd2, 64'h00000000_000000FF, 64'h00000000_00000001, 64'h00000000_000000FF, 8'h01},
        // R3: 16-bit unsigned clamp add
        '{2'b01, 3'd2, 64'h00000000_0001FFF0, 64'h00000000_00020020, 64'h00000000_0003FFFF, 8'h01},
        // R4: 8-bit unsigned clamp subtract
        '{2'b00, 3'd3, 64'h00000000_00001005, 64'h00000000_00000809, 64'h00000000_00000800, 8'h01},
        // R2: 8-bit modular subtract, borrow cut
        '{2'b00, 3'd1, 64'h00000000_00000005, 64'h00000000_00000009, 64'h00000000_000000FC, 8'h00},
        // R5: 8-bit signed clamp add, both directions
        '{2'b00, 3'd4, 64'h00000000_00007F80, 64'h00000000_000001FF, 64'h00000000_00007F80, 8'h03},
        // R5: 16-bit signed clamp subtract
        '{2'b01, 3'd5, 64'h00000005_80007FFF, 64'h00000003_0001FFFF, 64'h00000002_80007FFF, 8'h03},
        // R5: 32-bit signed clamp add, lane 1 only
        '{2'b10, 3'd4, 64'h7FFFFFFF_00000010, 64'h00000001_FFFFFFF0, 64'h7FFFFFFF_00000000, 8'h02},
        // R6: 8-bit rounded mean incl. FF+FF
        '{2'b00, 3'd6, 64'h00000000_0000FF03, 64'h00000000_0001FF04, 64'h00000000_0001FF04, 8'h00},
        // R6: 32-bit rounded mean at full scale
        '{2'b10, 3'd6, 64'hFFFFFFFF_00000002, 64'h00000000_00000001, 64'h80000000_00000002, 8'h00},
        // R1: reserved lane-size code
        '{2'b11, 3'd0, 64'h00000000_00000001, 64'h00000000_00000001, 64'h0, 8'h00},
        // R8: reserved op code
        '{2'b00, 3'd7, 64'h12345678_9ABCDEF0, 64'h11111111_11111111, 64'h0, 8'h00},
        // R3: 32-bit unsigned clamp add, lane 0 only
        '{2'b10, 3'd2, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000001, 64'hFFFFFFFF_FFFFFFFF, 8'h01},
        // R2: 16-bit modular add, carry cut
        '{2'b01, 3'd0, 64'h00000000_0000FFFF, 64'h00000000_00000001, 64'h0, 8'h00},
        // R1: same operands in 32-bit lanes carry into bit 16
        '{2'b10, 3'd0, 64'h00000000_0000FFFF, 64'h00000000_00000001, 64'h00000000_00010000, 8'h00},
        // R7: every 8-bit lane clamps, all eight flags
        '{2'b00, 3'd2, 64'hFFFFFFFF_FFFFFFFF, 64'h01010101_01010101, 64'hFFFFFFFF_FFFFFFFF, 8'hFF}
    };

    task automatic check(input string req, input logic [63:0] gr, input logic [63:0] er,
                         input logic [7:0] gf, input logic [7:0] ef);
        n_chk++;
        if (gr !== er || gf !== ef) begin
            n_bad++;
            $display("FAIL %s: res=%h sat=%h expected res=%h sat=%h", req, gr, gf, er, ef);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [2:0] o,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        lsel = s; op = o; opa = a; opb = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R9: outputs cleared while reset is held, despite live inputs
        opa = 64'hFFFFFFFF_FFFFFFFF; opb = 64'h01010101_01010101; op = 3'd2; lsel = 2'b00;
        repeat (3) @(negedge clk);
        check("R9 reset state", res, 64'h0, sat, 8'h00);
        rst_n = 1'b1;
        // R9: one-cycle latency, result visible after one edge
        @(negedge clk);
        check("R9 latency", res, 64'hFFFFFFFF_FFFFFFFF, sat, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].sz, VECS[i].op, VECS[i].a, VECS[i].b);
            check($sformatf("vector %0d", i), res, VECS[i].er, sat, VECS[i].ef);
        end

        // R7: 16-bit clamps leave flag bits 7:4 low
        apply(2'b01, 3'd2, 64'hFFFFFFFF_FFFFFFFF, 64'h00010001_00010001);
        check("R7 16-bit flags", res, 64'hFFFFFFFF_FFFFFFFF, sat, 8'h0F);
        // R4: equal operands give zero without clamp
        apply(2'b01, 3'd3, 64'h12341234_12341234, 64'h12341234_12341234);
        check("R4 equal operands", res, 64'h0, sat, 8'h00);
        // R5: signed subtract 32-bit min clamp
        apply(2'b10, 3'd5, 64'h80000000_00000000, 64'h00000001_00000001);
        check("R5 32-bit min clamp", res, 64'h80000000_FFFFFFFF, sat, 8'h02);

        // R9: reset mid-stream clears the registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears", res, 64'h0, sat, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule